// File: doc/BRIEF.md
# Signed-Count Bidirectional Barrel Shifter

This block shifts a 16-bit operand in one pass of combinational logic. A single signed shift count sets both the direction and the distance of the shift. A positive count shifts right and a negative count shifts left. A count of zero lets the operand through unchanged. When the shift is to the right, a select input chooses between zero fill (logical) and sign fill (arithmetic). A left shift always brings in zeros.

The count is a 6-bit two's-complement value, so it runs from -32 to +31. Any distance larger than 16 is treated as 16. The block also gives two indicators taken from the shifted value: one shows an all-zero result, the other shows a negative result. A control decoder turns the count into a small bundle of strobes. A datapath of five mux stages (1, 2, 4, 8 and 16) carries out the shift. Left shifts reuse the right-shift tree: the operand is bit-reversed on entry and the result is reversed again on exit.

Top module: `sc_barrel_shift`

## Requirements
- R1: When shiftCount is 0, result equals opData bit for bit, whatever arithRight is.
- R2: A count c from 1 to 15 shifts right by c. With arithRight=0 the vacated upper bits are 0.
- R3: With arithRight=1 and a positive count, the vacated upper bits copy opData[15].
- R4: A negative count c shifts left by -c, the vacated lower bits are 0, and arithRight has no effect on the result.
- R5: shiftCount is a 6-bit two's-complement value (-32 to +31). A magnitude of 16 or more acts as 16. A logical right shift or a left shift of 16 gives 0x0000. An arithmetic right shift of 16 gives 16 copies of opData[15].
- R6: isZero is 1 exactly when result is 0x0000.
- R7: isNeg equals result[15].
- R8: The block has no clock or storage: result and the indicators follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opData | input | 16 | Operand to shift |
| shiftCount | input | 6 | Signed count: positive shifts right, negative shifts left |
| arithRight | input | 1 | 1 selects sign fill for right shifts |
| result | output | 16 | Shifted value |
| isZero | output | 1 | Result is all zeros |
| isNeg | output | 1 | Top bit of result |

## Verification
The bench covers the count extremes +1, -1, +15, -15, +16, -16, +31 and -32. A decoder that negates the count wrongly, or that does not clamp it, would use the wrong stage enables there, so -32 could act as no shift, or +31 could wrap to a short shift. Arithmetic shifts are run on operands with the sign bit both set and clear. A fill taken from the wrong bit, or sign fill leaking into left shifts, shows up as wrong upper or lower bits. A full sweep of every count on several operands catches a missing or misordered reversal, which would turn a left shift into a mirrored right shift. It also catches a stage tied to the wrong distance.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;
  localparam int SHIFT_DATA_W = 16;
  localparam int SHIFT_CNT_W  = 6;
  localparam int SHIFT_STG_N  = $clog2(SHIFT_DATA_W) + 1;

  // Strobes from count decoder to mux tree
  typedef struct packed {
    logic                   goLeft;
    logic                   signFill;
    logic [SHIFT_STG_N-1:0] stageEn;
  } shift_ctl_t;
endpackage

// File: rtl/sc_shift_ctrl.sv
module sc_shift_ctrl
  import sc_shift_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  parameter int CNT_W  = SHIFT_CNT_W,
  localparam int STG_N = $clog2(DATA_W) + 1
) (
  input  logic [CNT_W-1:0] shiftCount,
  input  logic             arithRight,
  output shift_ctl_t       ctl
);
  logic             cntNeg;
  logic [CNT_W-1:0] magRaw;
  logic [STG_N-1:0] magClamped;

  always_comb begin
    cntNeg     = shiftCount[CNT_W-1];
    magRaw     = cntNeg ? (~shiftCount + 1'b1) : shiftCount;
    magClamped = (magRaw > CNT_W'(DATA_W)) ? STG_N'(DATA_W) : magRaw[STG_N-1:0];
    ctl.goLeft   = cntNeg;
    ctl.signFill = arithRight & ~cntNeg;
    ctl.stageEn  = magClamped;
  end

  always_comb begin
    if (!$isunknown(shiftCount))
      AST_CLAMP_ONEHOT: assert (!(magRaw >= CNT_W'(DATA_W)) || $onehot0(ctl.stageEn)) // R5
        else $error("clamped magnitude not a single stage");
  end
endmodule

// File: rtl/sc_shift_dpath.sv
module sc_shift_dpath
  import sc_shift_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  localparam int STG_N = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] opData,
  input  shift_ctl_t        ctl,
  output logic [DATA_W-1:0] shiftOut
);
  logic              fillBit;
  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stg [STG_N+1];

  assign fillBit = ctl.signFill & opData[DATA_W-1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revIn[i]  = opData[DATA_W-1-i];
    assign revOut[i] = stg[STG_N][DATA_W-1-i];
  end

  assign stg[0] = ctl.goLeft ? revIn : opData;

  for (genvar k = 0; k < STG_N; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= DATA_W) begin : g_full
      assign stg[k+1] = ctl.stageEn[k] ? {DATA_W{fillBit}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = ctl.stageEn[k] ? {{SH{fillBit}}, stg[k][DATA_W-1:SH]} : stg[k];
    end
  end

  assign shiftOut = ctl.goLeft ? revOut : stg[STG_N];

  always_comb begin
    if (!$isunknown({opData, ctl}))
      AST_LEFT_NO_SIGN: assert (!ctl.goLeft || !fillBit) // R4
        else $error("sign fill used on left shift");
  end
endmodule

// File: rtl/sc_barrel_shift.sv
module sc_barrel_shift
  import sc_shift_pkg::*;
#(
  parameter int DATA_W = SHIFT_DATA_W,
  parameter int CNT_W  = SHIFT_CNT_W
) (
  input  logic [DATA_W-1:0] opData,
  input  logic [CNT_W-1:0]  shiftCount,
  input  logic              arithRight,
  output logic [DATA_W-1:0] result,
  output logic              isZero,
  output logic              isNeg
);
  shift_ctl_t ctl;

  sc_shift_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .shiftCount(shiftCount),
    .arithRight(arithRight),
    .ctl       (ctl)
  );

  sc_shift_dpath #(.DATA_W(DATA_W)) u_dpath (
    .opData  (opData),
    .ctl     (ctl),
    .shiftOut(result)
  );

  assign isZero = (result == '0);
  assign isNeg  = result[DATA_W-1];

  logic cntPos;
  logic cntLeft;
  assign cntPos  = !shiftCount[CNT_W-1] && (shiftCount != '0);
  assign cntLeft = shiftCount[CNT_W-1];

  always_comb begin
    if (!$isunknown({opData, shiftCount, arithRight, result})) begin
      AST_ZERO_PASS: assert (shiftCount != '0 || result == opData) // R1
        else $error("zero count altered operand");
      AST_LOGIC_TOP_CLEAR: assert (!(cntPos && !arithRight) || !result[DATA_W-1]) // R2
        else $error("logical right shift kept top bit");
      AST_ARITH_SIGN_KEEP: assert (!(cntPos && arithRight) || result[DATA_W-1] == opData[DATA_W-1]) // R3
        else $error("arithmetic shift lost sign");
      AST_LEFT_LSB_CLEAR: assert (!cntLeft || !result[0]) // R4
        else $error("left shift filled nonzero");
      AST_ARITH_FULL_FILL: assert (!(cntPos && arithRight && shiftCount >= CNT_W'(DATA_W))
                                   || result == {DATA_W{opData[DATA_W-1]}}) // R5
        else $error("full arithmetic shift wrong");
    end
  end
endmodule

// File: tb/test_sc_barrel_shift.sv
module test_sc_barrel_shift;
  logic        clk = 1'b0;
  logic [15:0] opData = '0;
  logic [5:0]  shiftCount = '0;
  logic        arithRight = 1'b0;
  logic [15:0] result;
  logic        isZero, isNeg;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sc_barrel_shift i_sc_barrel_shift (
    .opData(opData), .shiftCount(shiftCount), .arithRight(arithRight),
    .result(result), .isZero(isZero), .isNeg(isNeg)
  );

  function automatic logic [15:0] refShift(logic [15:0] op, int cnt, bit ar);
    int m;
    logic [31:0] w;
    if (cnt == 0) return op;
    m = (cnt < 0) ? -cnt : cnt;
    if (m > 16) m = 16;
    if (cnt < 0) begin
      w = {16'h0, op} << m;
      return w[15:0];
    end
    w = {(ar && op[15]) ? 16'hFFFF : 16'h0000, op} >> m;
    return w[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (op=%h cnt=%0d ar=%0b)",
               req, act, exp, opData, $signed(shiftCount), arithRight);
    end
  endtask

  task automatic apply(logic [15:0] op, int cnt, bit ar);
    @(negedge clk);
    opData = op; shiftCount = 6'(cnt); arithRight = ar;
    #2;
  endtask

  task automatic runOne(string req, logic [15:0] op, int cnt, bit ar);
    logic [15:0] e;
    apply(op, cnt, ar);
    e = refShift(op, cnt, ar);
    check(req, result, e);
    check("R6", {15'h0, isZero}, {15'h0, e == 16'h0});
    check("R7", {15'h0, isNeg}, {15'h0, e[15]});
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    check("R1", result, 16'h0000);
    check("R6", {15'h0, isZero}, 16'h1);
  endtask

  task automatic t_zero_pass;   // R1
    runOne("R1", 16'hA5C3, 0, 1'b0);
    runOne("R1", 16'h8001, 0, 1'b1);
  endtask

  task automatic t_right_logic; // R2
    runOne("R2", 16'hF00F, 1, 1'b0);
    runOne("R2", 16'h8000, 15, 1'b0);
    runOne("R2", 16'h1234, 4, 1'b0);
  endtask

  task automatic t_right_arith; // R3
    runOne("R3", 16'h8000, 15, 1'b1);
    runOne("R3", 16'hC350, 3, 1'b1);
    runOne("R3", 16'h7FFF, 7, 1'b1);
  endtask

  task automatic t_left;        // R4
    runOne("R4", 16'h0001, -1, 1'b0);
    runOne("R4", 16'h0001, -15, 1'b1);
    runOne("R4", 16'hFFFF, -8, 1'b1);
  endtask

  task automatic t_clamp;       // R5
    runOne("R5", 16'hFFFF, 16, 1'b0);
    runOne("R5", 16'h8000, 16, 1'b1);
    runOne("R5", 16'h9ABC, 31, 1'b1);
    runOne("R5", 16'h1ABC, 31, 1'b1);
    runOne("R5", 16'hFFFF, -16, 1'b1);
    runOne("R5", 16'hFFFF, -32, 1'b0);
  endtask

  task automatic t_same_cycle;  // R8
    apply(16'h00F0, 4, 1'b0);
    check("R8", result, 16'h000F);
    opData = 16'h0F00; #1;
    check("R8", result, 16'h00F0);
  endtask

  task automatic t_sweep;       // R2 R3 R4 R5 over every count
    logic [15:0] ops [4] = '{16'h8001, 16'h7FFE, 16'hB6D9, 16'h0000};
    for (int o = 0; o < 4; o++)
      for (int c = -32; c < 32; c++)
        for (int a = 0; a < 2; a++)
          runOne((c > 0) ? (a ? "R3" : "R2") : (c < 0 ? "R4" : "R1"), ops[o], c, a[0]);
  endtask

  initial begin
    t_reset();
    t_zero_pass();
    t_right_logic();
    t_right_arith();
    t_left();
    t_clamp();
    t_same_cycle();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule